// File: doc/BRIEF.md
# Iterative Multiply and Divide Arithmetic Unit

This block is a small bus-mapped arithmetic engine. Software loads operand bytes through a byte-wide write port. It then reads result bytes back through a byte-wide read port. Two unsigned operations are available: a byte-by-byte multiply and a halfword-by-byte divide. Each one starts as soon as its last operand, the multiplier or the divisor, is written.

The datapath resolves one bit per clock. A multiply shifts and adds for as many clocks as the byte is wide. A divide shifts and subtracts for as many clocks as the halfword is wide. Both result registers can be read at any time and show the partial state while an operation is running. The multiply product and the divide remainder share one result register, so the most recent operation owns it. A `busy` output tells the caller when the result is final. A new start write aborts any running operation.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, `busy` is 0 and all four result bytes read 0.
- R2: A write to `wr_sel`=1 (multiplier) starts an unsigned multiply of that byte by the multiplicand held at `wr_sel`=0. Exactly 8 clocks after the start write, the 16-bit product is readable at `rd_sel`=2 (low byte) and `rd_sel`=3 (high byte).
- R3: The dividend is written low byte at `wr_sel`=2 and high byte at `wr_sel`=3. A write to `wr_sel`=4 (divisor) starts an unsigned divide. Exactly 16 clocks after that write, the quotient reads at `rd_sel`=0/1 (low/high) and the remainder at `rd_sel`=2/3.
- R4: The divide remainder replaces any earlier product in the shared result register, and the reverse also holds.
- R5: `busy` rises on the clock edge that takes a start write. It stays high until the edge that finalises the result and is low from then on.
- R6: After k clocks of a multiply, the result register holds the multiplicand times the low k bits of the multiplier.
- R7: A divide by zero yields quotient 0xFFFF and a remainder equal to the dividend.
- R8: A start write during a running operation abandons it. The new operation runs its full clock count from its own write, using the operands current at that write.
- R9: Operand writes made while an operation runs do not change its result. While the unit is idle, both result registers keep their values.
- R10: Writes to `wr_sel` 0, 2, 3 and to the unused codes 5 to 7 start nothing: `busy` stays 0 and the results are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one operand byte |
| wr_sel | input | 3 | Operand register select for a write |
| wr_data | input | 8 | Write data byte |
| rd_sel | input | 2 | Result byte select for a read |
| rd_data | output | 8 | Selected result byte (combinational) |
| busy | output | 1 | Operation in progress |

## Verification
On every clock, the assertions check three things. Each start write raises `busy`. `busy` falls after exactly 8 or 16 steps, counted from the most recent start. At that fall, the product, quotient and remainder match values computed from the operands captured at the start, including the zero-divisor case. They also check that idle results hold still and that non-start writes never raise `busy`. Other behaviours are visible only in the bench's scenarios: the partial products seen mid-multiply, the byte lane placement at the read port, and the aborts and late operand writes in their specific orders.

// File: rtl/muldiv_pkg.sv
`timescale 1ns/1ps
package muldiv_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_MUL  = 2'd1,
    OP_DIV  = 2'd2
  } op_e;

  localparam int WSEL_W = 3;
  localparam int RSEL_W = 2;

  localparam logic [WSEL_W-1:0] WSEL_MCAND   = 3'd0;
  localparam logic [WSEL_W-1:0] WSEL_MPLIER  = 3'd1;
  localparam logic [WSEL_W-1:0] WSEL_DVD_LO  = 3'd2;
  localparam logic [WSEL_W-1:0] WSEL_DVD_HI  = 3'd3;
  localparam logic [WSEL_W-1:0] WSEL_DIVISOR = 3'd4;
endpackage

// File: rtl/muldiv_opregs.sv
`timescale 1ns/1ps
module muldiv_opregs
  import muldiv_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [WSEL_W-1:0]     wr_sel,
  input  logic [OP_W-1:0]       wr_data,
  output logic [OP_W-1:0]       mcand_q,
  output logic [2*OP_W-1:0]     dividend_q,
  output logic                  start_mul,
  output logic                  start_div
);
  localparam int HALVES = 2;

  assign start_mul = wr_en && (wr_sel == WSEL_MPLIER);
  assign start_div = wr_en && (wr_sel == WSEL_DIVISOR);

  always_ff @(posedge clk) begin
    if (!rst_n)
      mcand_q <= '0;
    else if (wr_en && wr_sel == WSEL_MCAND)
      mcand_q <= wr_data;
  end

  // one register per dividend half, selected by consecutive codes
  for (genvar h = 0; h < HALVES; h++) begin : g_dvd
    always_ff @(posedge clk) begin
      if (!rst_n)
        dividend_q[h*OP_W +: OP_W] <= '0;
      else if (wr_en && wr_sel == WSEL_DVD_LO + WSEL_W'(h))
        dividend_q[h*OP_W +: OP_W] <= wr_data;
    end
  end
endmodule

// File: rtl/muldiv_core.sv
`timescale 1ns/1ps
module muldiv_core
  import muldiv_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_mul,
  input  logic                  start_div,
  input  logic [OP_W-1:0]       mcand_in,
  input  logic [OP_W-1:0]       mplier_in,
  input  logic [2*OP_W-1:0]     dividend_in,
  input  logic [OP_W-1:0]       divisor_in,
  output logic                  busy,
  output logic                  last_step,
  output logic [2*OP_W-1:0]     quo_q,
  output logic [2*OP_W-1:0]     res_q
);
  localparam int WIDE_W = 2 * OP_W;
  localparam int CNT_W  = $clog2(WIDE_W + 1);

  // add the shifted multiplicand when the current multiplier bit is set
  function automatic logic [WIDE_W-1:0] mul_acc(input logic [WIDE_W-1:0] acc,
                                                input logic [WIDE_W-1:0] addend,
                                                input logic              take);
    return take ? acc + addend : acc;
  endfunction

  // shift one dividend bit into the partial remainder and try a subtract;
  // result is {quotient bit, new remainder}
  function automatic logic [WIDE_W:0] div_trial(input logic [WIDE_W-1:0] rem,
                                                input logic              nxt,
                                                input logic [OP_W-1:0]   dvs);
    logic [WIDE_W:0] sh;
    logic [WIDE_W:0] dv;
    sh = {rem, nxt};
    dv = {{(WIDE_W + 1 - OP_W){1'b0}}, dvs};
    if (sh >= dv) return {1'b1, WIDE_W'(sh - dv)};
    return {1'b0, sh[WIDE_W-1:0]};
  endfunction

  op_e               op_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WIDE_W-1:0] mcand_q;
  logic [OP_W-1:0]   mplier_q;
  logic [OP_W-1:0]   dvs_q;
  logic [WIDE_W:0]   trial;

  assign trial     = div_trial(res_q, quo_q[WIDE_W-1], dvs_q);
  assign busy      = (op_q != OP_IDLE);
  assign last_step = busy && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q     <= OP_IDLE;
      cnt_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
      dvs_q    <= '0;
      quo_q    <= '0;
      res_q    <= '0;
    end else if (start_mul) begin
      op_q     <= OP_MUL;
      cnt_q    <= CNT_W'(OP_W);
      res_q    <= '0;
      mcand_q  <= {{OP_W{1'b0}}, mcand_in};
      mplier_q <= mplier_in;
    end else if (start_div) begin
      op_q     <= OP_DIV;
      cnt_q    <= CNT_W'(WIDE_W);
      res_q    <= '0;
      quo_q    <= dividend_in;
      dvs_q    <= divisor_in;
    end else begin
      case (op_q)
        OP_MUL: begin
          res_q    <= mul_acc(res_q, mcand_q, mplier_q[0]);
          mcand_q  <= mcand_q << 1;
          mplier_q <= mplier_q >> 1;
        end
        OP_DIV: begin
          res_q <= trial[WIDE_W-1:0];
          quo_q <= {quo_q[WIDE_W-2:0], trial[WIDE_W]};
        end
        default: ;
      endcase
      if (busy) begin
        cnt_q <= cnt_q - CNT_W'(1);
        if (last_step) op_q <= OP_IDLE;
      end
    end
  end
endmodule

// File: rtl/muldiv_rdmux.sv
`timescale 1ns/1ps
module muldiv_rdmux
  import muldiv_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic [2*OP_W-1:0]  quo,
  input  logic [2*OP_W-1:0]  res,
  input  logic [RSEL_W-1:0]  rd_sel,
  output logic [OP_W-1:0]    rd_data
);
  localparam int LANES = 1 << RSEL_W;
  localparam int HALF  = LANES / 2;

  logic [OP_W-1:0] lane [LANES];

  for (genvar g = 0; g < HALF; g++) begin : g_lane
    assign lane[g]        = quo[g*OP_W +: OP_W];
    assign lane[HALF + g] = res[g*OP_W +: OP_W];
  end

  assign rd_data = lane[rd_sel];
endmodule

// File: rtl/muldiv_unit.sv
`timescale 1ns/1ps
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [OP_W-1:0]   wr_data,
  input  logic [1:0]        rd_sel,
  output logic [OP_W-1:0]   rd_data,
  output logic              busy
);
  localparam int WIDE_W = 2 * OP_W;

  logic [OP_W-1:0]   mcand_q;
  logic [WIDE_W-1:0] dividend_q;
  logic              start_mul;
  logic              start_div;
  logic              last_step;
  logic [WIDE_W-1:0] quo_q;
  logic [WIDE_W-1:0] res_q;

  muldiv_opregs #(.OP_W(OP_W)) u_opregs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .mcand_q    (mcand_q),
    .dividend_q (dividend_q),
    .start_mul  (start_mul),
    .start_div  (start_div)
  );

  muldiv_core #(.OP_W(OP_W)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_mul   (start_mul),
    .start_div   (start_div),
    .mcand_in    (mcand_q),
    .mplier_in   (wr_data),
    .dividend_in (dividend_q),
    .divisor_in  (wr_data),
    .busy        (busy),
    .last_step   (last_step),
    .quo_q       (quo_q),
    .res_q       (res_q)
  );

  muldiv_rdmux #(.OP_W(OP_W)) u_rdmux (
    .quo     (quo_q),
    .res     (res_q),
    .rd_sel  (rd_sel),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/muldiv_unit_chk.sv
`timescale 1ns/1ps
module muldiv_unit_chk
  import muldiv_pkg::*;
#(
  parameter int OP_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [2:0]        wr_sel,
  input logic [OP_W-1:0]   wr_data,
  input logic              busy,
  input logic              last_step,
  input logic [OP_W-1:0]   mcand,
  input logic [2*OP_W-1:0] dividend,
  input logic [2*OP_W-1:0] quo,
  input logic [2*OP_W-1:0] res
);
  localparam int WIDE_W = 2 * OP_W;
  localparam int CNT_W  = $clog2(WIDE_W + 1);

  logic              st_m;
  logic              st_d;
  logic              nonstart_wr;
  logic [CNT_W-1:0]  cyc;
  logic              kind_div;
  logic [WIDE_W-1:0] exp_quo;
  logic [WIDE_W-1:0] exp_res;

  assign st_m        = wr_en && (wr_sel == WSEL_MPLIER);
  assign st_d        = wr_en && (wr_sel == WSEL_DIVISOR);
  assign nonstart_wr = wr_en && !st_m && !st_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc      <= '0;
      kind_div <= 1'b0;
      exp_quo  <= '0;
      exp_res  <= '0;
    end else if (st_m) begin
      cyc      <= '0;
      kind_div <= 1'b0;
      exp_res  <= WIDE_W'(mcand) * WIDE_W'(wr_data);
    end else if (st_d) begin
      cyc      <= '0;
      kind_div <= 1'b1;
      exp_quo  <= (wr_data == '0) ? '1 : dividend / WIDE_W'(wr_data);
      exp_res  <= (wr_data == '0) ? dividend : dividend % WIDE_W'(wr_data);
    end else if (busy) begin
      cyc <= cyc + CNT_W'(1);
    end
  end

  // R5
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_m || st_d) |=> busy);

  // R5
  last_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_step && !st_m && !st_d) |=> !busy);

  // R8
  finish_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (cyc == (kind_div ? CNT_W'(WIDE_W) : CNT_W'(OP_W))));

  // R2
  mul_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !kind_div) |-> (res == exp_res));

  // R7
  div_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && kind_div) |-> (quo == exp_quo && res == exp_res));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !st_m && !st_d) |=> ($stable(res) && $stable(quo)));

  // R10
  no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nonstart_wr && !busy) |=> !busy);
endmodule

bind muldiv_unit muldiv_unit_chk #(.OP_W(OP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .wr_data   (wr_data),
  .busy      (busy),
  .last_step (last_step),
  .mcand     (mcand_q),
  .dividend  (dividend_q),
  .quo       (quo_q),
  .res       (res_q)
);

// File: tb/muldiv_unit_test.sv
`timescale 1ns/1ps
module muldiv_unit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_sel = '0;
  logic [7:0] rd_data;
  logic       busy;

  int errors = 0;
  int checks = 0;
  bit fin = 1'b0;

  // bit 24: 1 = divide; [23:8] first operand; [7:0] second operand
  localparam logic [24:0] VECS [8] = '{
    {1'b0, 16'h00FF, 8'hFF},
    {1'b0, 16'h0012, 8'h34},
    {1'b0, 16'h0000, 8'h7F},
    {1'b0, 16'h0080, 8'h02},
    {1'b1, 16'hFFFF, 8'h01},
    {1'b1, 16'h1234, 8'h56},
    {1'b1, 16'h0007, 8'h09},
    {1'b1, 16'hABCD, 8'hFF}
  };

  muldiv_unit uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .rd_sel  (rd_sel),
    .rd_data (rd_data),
    .busy    (busy)
  );

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd16(input logic [1:0] base, output logic [15:0] v);
    rd_sel = base;        #1 v[7:0]  = rd_data;
    rd_sel = base + 2'd1; #1 v[15:8] = rd_data;
  endtask

  task automatic wait_done(input int steps, input string tag);
    repeat (steps - 1) @(posedge clk);
    @(negedge clk);
    chk({tag, " busy before last step"}, 16'(busy), 16'd1);
    @(posedge clk);
    @(negedge clk);
    chk({tag, " busy after last step"}, 16'(busy), 16'd0);
  endtask

  task automatic run_mul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] v;
    wr(3'd0, a);
    wr(3'd1, b);
    wait_done(8, "R2 R5");
    rd16(2'd2, v);
    chk("R2 R4 product", v, 16'(a) * 16'(b));
  endtask

  task automatic run_div(input logic [15:0] n, input logic [7:0] d);
    logic [15:0] q, r, eq, er;
    wr(3'd2, n[7:0]);
    wr(3'd3, n[15:8]);
    wr(3'd4, d);
    wait_done(16, "R3 R5");
    if (d == 8'd0) begin eq = 16'hFFFF; er = n; end
    else begin eq = n / 16'(d); er = n % 16'(d); end
    rd16(2'd0, q);
    rd16(2'd2, r);
    chk("R3 quotient", q, eq);
    chk("R3 R4 remainder", r, er);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      errors++; checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, q0, r0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 busy", 16'(busy), 16'd0);
    rd16(2'd0, v); chk("R1 quotient", v, 16'h0000);
    rd16(2'd2, v); chk("R1 result", v, 16'h0000);

    foreach (VECS[i]) begin
      if (VECS[i][24]) run_div(VECS[i][23:8], VECS[i][7:0]);
      else             run_mul(VECS[i][15:8], VECS[i][7:0]);
    end

    // R7 divide by zero
    run_div(16'h1234, 8'h00);

    // R6 partial products: 0x10 * 0x03
    wr(3'd0, 8'h10);
    wr(3'd1, 8'h03);
    @(posedge clk); @(negedge clk);
    rd16(2'd2, v); chk("R6 after one step", v, 16'h0010);
    @(posedge clk); @(negedge clk);
    rd16(2'd2, v); chk("R6 after two steps", v, 16'h0030);
    wait_done(6, "R6");
    rd16(2'd2, v); chk("R6 final", v, 16'h0030);

    // R8 multiply restarted by a new multiplier write
    wr(3'd0, 8'h02);
    wr(3'd1, 8'h03);
    repeat (3) @(posedge clk);
    wr(3'd1, 8'h05);
    wait_done(8, "R8 mul restart");
    rd16(2'd2, v); chk("R8 restarted product", v, 16'h000A);

    // R8 multiply aborted by a divide start
    wr(3'd0, 8'hFF);
    wr(3'd1, 8'hFF);
    wr(3'd2, 8'h00);
    wr(3'd3, 8'h10);
    wr(3'd4, 8'h10);
    wait_done(16, "R8 mul to div");
    rd16(2'd0, v); chk("R8 quotient", v, 16'h0100);
    rd16(2'd2, v); chk("R8 remainder", v, 16'h0000);

    // R9 operand writes during a divide: 100 / 7
    wr(3'd2, 8'h64);
    wr(3'd3, 8'h00);
    wr(3'd4, 8'h07);
    wr(3'd2, 8'hFF);
    wr(3'd3, 8'hFF);
    wr(3'd0, 8'h99);
    repeat (12) @(posedge clk);
    @(negedge clk);
    chk("R9 busy before end", 16'(busy), 16'd1);
    @(posedge clk); @(negedge clk);
    chk("R9 busy after end", 16'(busy), 16'd0);
    rd16(2'd0, v); chk("R9 quotient", v, 16'd14);
    rd16(2'd2, v); chk("R9 remainder", v, 16'd2);

    // R10 non-start writes while idle
    rd16(2'd0, q0);
    rd16(2'd2, r0);
    wr(3'd0, 8'hAA);
    wr(3'd2, 8'h55);
    wr(3'd5, 8'h77);
    wr(3'd7, 8'h01);
    @(negedge clk);
    chk("R10 busy", 16'(busy), 16'd0);
    rd16(2'd0, v); chk("R10 quotient held", v, q0);
    rd16(2'd2, v); chk("R10 result held", v, r0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    rd16(2'd2, v); chk("R9 idle hold", v, r0);

    fin = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule